// File: doc/BRIEF.md
# DMA Burst Legalizer

This block sits between a one-dimensional copy request and the read and write bus engines of a DMA. It accepts a source address, a destination address and a byte count over a valid/ready handshake. It then emits two independent streams of bursts, one for reading and one for writing. Every burst in both streams is legal on its bus. It moves no data. It only computes where each burst starts, how many bytes and beats it covers, and how the data path must rotate and mask byte lanes.

Each side holds its own current address and remaining byte count. Their split points are therefore independent: the read side may cut at a page edge while the write side cuts at a word edge. By default the read side bursts up to a 4 KiB page. The write side runs in single-beat mode by default, which models a non-bursting write protocol. A request of zero bytes is refused with a one-cycle error pulse. A new request is taken only after both sides have finished the previous one.

Top module: `dma_burst_legalizer`

## Requirements
- R1: No burst on either side crosses a 4096-byte address boundary: (addr mod 4096) + bytes <= 4096.
- R2: A bursting side's largest burst is min(4096, 256 × byte lanes) bytes. With the default 16 lanes this is 4096 bytes. The beats field equals the number of bus beats minus one, where beats = ceil(((addr mod 16) + bytes) / 16).
- R3: A 5000-byte request with source 0xFF8 produces exactly three read bursts: 8 bytes at 0xFF8, 4096 bytes at 0x1000 and 896 bytes at 0x2000.
- R4: With WR_SINGLE=1, every write burst stays inside one 16-byte bus word and carries a beats field of 0.
- R5: The read stream starts at the source address and the write stream starts at the destination address. Each stream is contiguous, and its byte counts add up to the request length.
- R6: With REJECT_ZERO=1, a zero-length request is accepted, err_o is high for exactly the one cycle after acceptance, and no burst appears on either side.
- R7: Each burst carries offset = addr mod 16 and tailer = (16 − ((addr + bytes) mod 16)) mod 16. While a request is active, shift_o = (src − dst) mod 16.
- R8: req_ready_o is high exactly when neither side is busy.
- R9: A burst presented with ready low stays valid with unchanged address and size. A side's address advances only on a completed handshake.
- R10: A side's busy flag rises in the cycle after a non-zero request is accepted. It falls in the cycle after that side's last burst is accepted.
- R11: The last flag is set on, and only on, the final burst of each side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Copy request valid |
| req_ready_o | output | 1 | Copy request ready |
| req_src_i | input | ADDR_W | Source byte address |
| req_dst_i | input | ADDR_W | Destination byte address |
| req_len_i | input | LEN_W | Length in bytes |
| err_o | output | 1 | One-cycle pulse for a refused zero-length request |
| shift_o | output | log2(DATA_W/8) | Source-to-destination lane rotation |
| rd_valid_o | output | 1 | Read burst valid |
| rd_ready_i | input | 1 | Read burst ready |
| rd_addr_o | output | ADDR_W | Read burst start address |
| rd_bytes_o | output | LEN_W | Read burst byte count |
| rd_beats_o | output | 8 | Read beats minus one |
| rd_offset_o | output | log2(DATA_W/8) | First valid lane of read burst |
| rd_tailer_o | output | log2(DATA_W/8) | Unused trailing lanes of read burst |
| rd_last_o | output | 1 | Final read burst of the request |
| rd_busy_o | output | 1 | Read side busy |
| wr_valid_o | output | 1 | Write burst valid |
| wr_ready_i | input | 1 | Write burst ready |
| wr_addr_o | output | ADDR_W | Write burst start address |
| wr_bytes_o | output | LEN_W | Write burst byte count |
| wr_beats_o | output | 8 | Write beats minus one |
| wr_offset_o | output | log2(DATA_W/8) | First valid lane of write burst |
| wr_tailer_o | output | log2(DATA_W/8) | Unused trailing lanes of write burst |
| wr_last_o | output | 1 | Final write burst of the request |
| wr_busy_o | output | 1 | Write side busy |

## Verification
Two events can fall in the same cycle: a read-burst handshake and a write-burst handshake, including both final bursts together. A side's last handshake can also coincide with a stall on the other side. The bench toggles both ready inputs independently at random every cycle, so simultaneous, staggered and stalled handshakes all occur across many random requests. Each accepted burst is compared with a per-side queue built from the requirement formulas. Busy, last and req_ready are checked in every cycle against what the queues still hold.

// File: rtl/legalizer_pkg.sv
package legalizer_pkg;
    localparam int unsigned PAGE_BYTES = 4096;
    localparam int unsigned MAX_BEATS  = 256;

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/burst_calc.sv
// Combinational: size and lane controls of the next burst on one side.
module burst_calc #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 24,
    parameter int unsigned STRB   = 16,
    parameter int unsigned SPLIT  = 4096,
    parameter int unsigned BEAT_W = 8
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LEN_W-1:0]         rem_i,
    output logic [LEN_W-1:0]         bytes_o,
    output logic [BEAT_W-1:0]        beats_o,
    output logic [$clog2(STRB)-1:0]  offset_o,
    output logic [$clog2(STRB)-1:0]  tailer_o,
    output logic                     last_o
);
    localparam int unsigned OFF_W = $clog2(STRB);
    localparam int unsigned SPL_W = $clog2(SPLIT);

    logic [LEN_W-1:0] room, span;
    logic [OFF_W-1:0] end_lane;

    always_comb begin
        room     = LEN_W'(SPLIT) - LEN_W'(addr_i[SPL_W-1:0]);
        bytes_o  = (rem_i < room) ? rem_i : room;
        offset_o = addr_i[OFF_W-1:0];
        end_lane = offset_o + bytes_o[OFF_W-1:0];
        tailer_o = '0 - end_lane;
        span     = LEN_W'(offset_o) + bytes_o + LEN_W'(STRB - 1);
        beats_o  = BEAT_W'((span >> OFF_W) - LEN_W'(1));
        last_o   = (bytes_o == rem_i);
    end
endmodule

// File: rtl/legalizer_side.sv
// One side (read or write): address and remaining-length counters.
module legalizer_side #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 24,
    parameter int unsigned STRB   = 16,
    parameter int unsigned SPLIT  = 4096,
    parameter int unsigned BEAT_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        start_addr_i,
    input  logic [LEN_W-1:0]         start_len_i,
    input  logic                     ready_i,
    output logic                     valid_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [LEN_W-1:0]         bytes_o,
    output logic [BEAT_W-1:0]        beats_o,
    output logic [$clog2(STRB)-1:0]  offset_o,
    output logic [$clog2(STRB)-1:0]  tailer_o,
    output logic                     last_o
);
    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
    } side_st_t;

    side_st_t st_d, st_q;

    burst_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRB(STRB), .SPLIT(SPLIT), .BEAT_W(BEAT_W)
    ) calc_i (
        .addr_i   (st_q.addr),
        .rem_i    (st_q.rem),
        .bytes_o  (bytes_o),
        .beats_o  (beats_o),
        .offset_o (offset_o),
        .tailer_o (tailer_o),
        .last_o   (last_o)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.addr   = start_addr_i;
            st_d.rem    = start_len_i;
        end else if (st_q.active && ready_i) begin
            st_d.addr = st_q.addr + ADDR_W'(bytes_o);
            st_d.rem  = st_q.rem - bytes_o;
            if (last_o) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.active;
    assign addr_o  = st_q.addr;
endmodule

// File: rtl/dma_burst_legalizer.sv
module dma_burst_legalizer
    import legalizer_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 24,
    parameter int unsigned DATA_W      = 128,
    parameter bit          WR_SINGLE   = 1'b1,
    parameter bit          REJECT_ZERO = 1'b1
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              req_valid_i,
    output logic                              req_ready_o,
    input  logic [ADDR_W-1:0]                 req_src_i,
    input  logic [ADDR_W-1:0]                 req_dst_i,
    input  logic [LEN_W-1:0]                  req_len_i,
    output logic                              err_o,
    output logic [$clog2(DATA_W/8)-1:0]       shift_o,
    output logic                              rd_valid_o,
    input  logic                              rd_ready_i,
    output logic [ADDR_W-1:0]                 rd_addr_o,
    output logic [LEN_W-1:0]                  rd_bytes_o,
    output logic [$clog2(MAX_BEATS)-1:0]      rd_beats_o,
    output logic [$clog2(DATA_W/8)-1:0]       rd_offset_o,
    output logic [$clog2(DATA_W/8)-1:0]       rd_tailer_o,
    output logic                              rd_last_o,
    output logic                              rd_busy_o,
    output logic                              wr_valid_o,
    input  logic                              wr_ready_i,
    output logic [ADDR_W-1:0]                 wr_addr_o,
    output logic [LEN_W-1:0]                  wr_bytes_o,
    output logic [$clog2(MAX_BEATS)-1:0]      wr_beats_o,
    output logic [$clog2(DATA_W/8)-1:0]       wr_offset_o,
    output logic [$clog2(DATA_W/8)-1:0]       wr_tailer_o,
    output logic                              wr_last_o,
    output logic                              wr_busy_o
);
    localparam int unsigned STRB        = DATA_W / 8;
    localparam int unsigned OFF_W       = $clog2(STRB);
    localparam int unsigned BEAT_W      = $clog2(MAX_BEATS);
    localparam int unsigned BURST_SPLIT = min_u(PAGE_BYTES, MAX_BEATS * STRB);
    localparam int unsigned WR_SPLIT    = WR_SINGLE ? STRB : BURST_SPLIT;

    typedef struct packed {
        logic [OFF_W-1:0] shift;
        logic             err;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    accept, start;

    logic [1:0]        s_ready, s_valid, s_last;
    logic [ADDR_W-1:0] s_start_addr [2];
    logic [ADDR_W-1:0] s_addr       [2];
    logic [LEN_W-1:0]  s_bytes      [2];
    logic [BEAT_W-1:0] s_beats      [2];
    logic [OFF_W-1:0]  s_offset     [2];
    logic [OFF_W-1:0]  s_tailer     [2];

    assign req_ready_o     = !s_valid[0] && !s_valid[1];
    assign s_start_addr[0] = req_src_i;
    assign s_start_addr[1] = req_dst_i;
    assign s_ready         = {wr_ready_i, rd_ready_i};

    always_comb begin
        accept = req_valid_i && req_ready_o;
        start  = accept && (req_len_i != '0);
        st_d   = st_q;
        st_d.err = accept && (req_len_i == '0) && REJECT_ZERO;
        if (accept) st_d.shift = req_src_i[OFF_W-1:0] - req_dst_i[OFF_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Side 0 reads, side 1 writes; only the split size differs.
    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int unsigned SPLIT = (s == 0) ? BURST_SPLIT : WR_SPLIT;
        legalizer_side #(
            .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRB(STRB), .SPLIT(SPLIT), .BEAT_W(BEAT_W)
        ) side_i (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .start_i      (start),
            .start_addr_i (s_start_addr[s]),
            .start_len_i  (req_len_i),
            .ready_i      (s_ready[s]),
            .valid_o      (s_valid[s]),
            .addr_o       (s_addr[s]),
            .bytes_o      (s_bytes[s]),
            .beats_o      (s_beats[s]),
            .offset_o     (s_offset[s]),
            .tailer_o     (s_tailer[s]),
            .last_o       (s_last[s])
        );
    end

    assign err_o       = st_q.err;
    assign shift_o     = st_q.shift;
    assign rd_valid_o  = s_valid[0];
    assign rd_addr_o   = s_addr[0];
    assign rd_bytes_o  = s_bytes[0];
    assign rd_beats_o  = s_beats[0];
    assign rd_offset_o = s_offset[0];
    assign rd_tailer_o = s_tailer[0];
    assign rd_last_o   = s_last[0];
    assign rd_busy_o   = s_valid[0];
    assign wr_valid_o  = s_valid[1];
    assign wr_addr_o   = s_addr[1];
    assign wr_bytes_o  = s_bytes[1];
    assign wr_beats_o  = s_beats[1];
    assign wr_offset_o = s_offset[1];
    assign wr_tailer_o = s_tailer[1];
    assign wr_last_o   = s_last[1];
    assign wr_busy_o   = s_valid[1];
endmodule

// File: rtl/dma_burst_legalizer_chk.sv
module dma_burst_legalizer_chk
    import legalizer_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 24,
    parameter int unsigned DATA_W      = 128,
    parameter bit          WR_SINGLE   = 1'b1,
    parameter bit          REJECT_ZERO = 1'b1
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          req_valid_i,
    input logic                          req_ready_o,
    input logic [LEN_W-1:0]              req_len_i,
    input logic                          err_o,
    input logic                          rd_valid_o,
    input logic                          rd_ready_i,
    input logic [ADDR_W-1:0]             rd_addr_o,
    input logic [LEN_W-1:0]              rd_bytes_o,
    input logic                          rd_last_o,
    input logic                          rd_busy_o,
    input logic                          wr_valid_o,
    input logic                          wr_ready_i,
    input logic [ADDR_W-1:0]             wr_addr_o,
    input logic [LEN_W-1:0]              wr_bytes_o,
    input logic [$clog2(MAX_BEATS)-1:0]  wr_beats_o,
    input logic                          wr_last_o,
    input logic                          wr_busy_o
);
    localparam int unsigned STRB  = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(STRB);
    localparam int unsigned PB    = $clog2(PAGE_BYTES);
    localparam int unsigned SPLIT = min_u(PAGE_BYTES, MAX_BEATS * STRB);

    AST_RD_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> (LEN_W'(rd_addr_o[PB-1:0]) + rd_bytes_o) <= LEN_W'(PAGE_BYTES)); // R1
    AST_WR_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> (LEN_W'(wr_addr_o[PB-1:0]) + wr_bytes_o) <= LEN_W'(PAGE_BYTES)); // R1
    AST_RD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> (rd_bytes_o != '0) && (rd_bytes_o <= LEN_W'(SPLIT))); // R2
    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o) && $stable(rd_bytes_o)); // R9
    AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_bytes_o)); // R9
    AST_REQ_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_busy_o || wr_busy_o) |-> !req_ready_o); // R8
    AST_RD_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_busy_o) |-> $past(rd_ready_i && rd_last_o)); // R10
    AST_WR_LAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o && wr_ready_i && wr_last_o |=> !wr_busy_o); // R11

    if (WR_SINGLE) begin : g_single
        AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_valid_o |-> (wr_beats_o == '0) &&
                ((LEN_W'(wr_addr_o[OFF_W-1:0]) + wr_bytes_o) <= LEN_W'(STRB))); // R4
    end
    if (REJECT_ZERO) begin : g_zero
        AST_ZERO_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_valid_i && req_ready_o && (req_len_i == '0) |=> err_o && !rd_valid_o && !wr_valid_o); // R6
    end
endmodule

bind dma_burst_legalizer dma_burst_legalizer_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .WR_SINGLE(WR_SINGLE), .REJECT_ZERO(REJECT_ZERO)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_len_i(req_len_i), .err_o(err_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_bytes_o(rd_bytes_o), .rd_last_o(rd_last_o), .rd_busy_o(rd_busy_o),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_bytes_o(wr_bytes_o), .wr_beats_o(wr_beats_o), .wr_last_o(wr_last_o),
    .wr_busy_o(wr_busy_o)
);

// File: tb/dma_burst_legalizer_tb_top.sv
module dma_burst_legalizer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, rd_ready = 1'b0, wr_ready = 1'b0;
    logic [31:0] req_src = '0, req_dst = '0;
    logic [23:0] req_len = '0;
    logic        req_ready, err, rd_valid, rd_last, rd_busy, wr_valid, wr_last, wr_busy;
    logic [3:0]  shift, rd_off, rd_tail, wr_off, wr_tail;
    logic [31:0] rd_addr, wr_addr;
    logic [23:0] rd_bytes, wr_bytes;
    logic [7:0]  rd_beats, wr_beats;

    int vectors = 0;
    int fails   = 0;

    typedef struct {
        logic [31:0] addr;
        int bytes, beats, off, tail;
        bit last;
    } exp_t;
    exp_t rq[$];
    exp_t wq[$];

    always #5 clk = ~clk;

    dma_burst_legalizer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_src_i(req_src), .req_dst_i(req_dst), .req_len_i(req_len), .err_o(err),
        .shift_o(shift),
        .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr), .rd_bytes_o(rd_bytes),
        .rd_beats_o(rd_beats), .rd_offset_o(rd_off), .rd_tailer_o(rd_tail), .rd_last_o(rd_last),
        .rd_busy_o(rd_busy),
        .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_bytes_o(wr_bytes),
        .wr_beats_o(wr_beats), .wr_offset_o(wr_off), .wr_tailer_o(wr_tail), .wr_last_o(wr_last),
        .wr_busy_o(wr_busy)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference split: read side bursts to 4096 bytes, write side single 16-byte words.
    task automatic build(input bit is_rd, input logic [31:0] a0, input int len);
        longint a = a0;
        int rem = len;
        int split = is_rd ? 4096 : 16;
        while (rem > 0) begin
            int room = split - int'(a % split);
            int b = (rem < room) ? rem : room;
            exp_t e;
            e.addr  = a[31:0];
            e.bytes = b;
            e.off   = int'(a % 16);
            e.tail  = (16 - int'((a + b) % 16)) % 16;
            e.beats = (int'(a % 16) + b + 15) / 16 - 1;
            e.last  = (rem == b);
            if (is_rd) rq.push_back(e); else wq.push_back(e);
            a   += b;
            rem -= b;
        end
    endtask

    task automatic cmp(input string side, input exp_t e, input logic [31:0] addr, input int bytes,
                       input int beats, input int off, input int tail, input bit last);
        check("R5", {side, " addr"}, addr, e.addr);
        check("R1", {side, " bytes"}, bytes, e.bytes);
        check("R2", {side, " beats"}, beats, e.beats);
        check("R7", {side, " offset"}, off, e.off);
        check("R7", {side, " tailer"}, tail, e.tail);
        check("R11", {side, " last"}, last, e.last);
    endtask

    task automatic run_req(input logic [31:0] s, input logic [31:0] d, input int len, input string tag);
        int guard = 0;
        int rd_cnt = 0;
        bit rd_hold = 0, wr_hold = 0;
        logic [31:0] rd_hold_a = '0, wr_hold_a = '0;
        build(1'b1, s, len);
        build(1'b0, d, len);
        @(negedge clk);
        req_src = s; req_dst = d; req_len = 24'(len); req_valid = 1'b1;
        rd_ready = 1'b0; wr_ready = 1'b0;
        #1;
        check("R8", {tag, " ready when idle"}, req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            #1;
            check("R6", "err pulse", err, 1);
            check("R6", "no burst", {rd_valid, wr_valid}, 0);
            @(negedge clk); #1;
            check("R6", "err one cycle", err, 0);
            check("R6", "still no burst", {rd_valid, wr_valid}, 0);
            return;
        end
        while ((rq.size() != 0 || wq.size() != 0) && guard < 20000) begin
            guard++;
            rd_ready = ($urandom % 4) != 0;
            wr_ready = ($urandom % 3) != 0;
            #1;
            check("R10", "rd busy", rd_busy, rq.size() != 0);
            check("R10", "wr busy", wr_busy, wq.size() != 0);
            check("R8", "ready low while active", req_ready, 0);
            check("R7", "shift", shift, (s - d) & 32'hF);
            check("R6", "no err on nonzero", err, 0);
            if (rd_hold) check("R9", "rd held addr", {rd_valid, rd_addr}, {1'b1, rd_hold_a});
            if (wr_hold) check("R9", "wr held addr", {wr_valid, wr_addr}, {1'b1, wr_hold_a});
            rd_hold = rd_valid && !rd_ready; rd_hold_a = rd_addr;
            wr_hold = wr_valid && !wr_ready; wr_hold_a = wr_addr;
            if (rd_valid && rd_ready && rq.size() != 0) begin
                exp_t e = rq.pop_front();
                rd_cnt++;
                cmp("rd", e, rd_addr, int'(rd_bytes), int'(rd_beats), int'(rd_off), int'(rd_tail), rd_last);
            end
            if (wr_valid && wr_ready && wq.size() != 0) begin
                exp_t e = wq.pop_front();
                check("R4", "wr single beat", wr_beats, 0);
                cmp("wr", e, wr_addr, int'(wr_bytes), int'(wr_beats), int'(wr_off), int'(wr_tail), wr_last);
            end
            @(negedge clk);
        end
        rd_ready = 1'b0; wr_ready = 1'b0;
        #1;
        check("R10", "busy cleared", {rd_busy, wr_busy}, 0);
        check("R8", "ready after done", req_ready, 1);
        if (tag == "R3") check("R3", "read burst count", rd_cnt, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10", "reset busy", {rd_busy, wr_busy}, 0);
        check("R8", "reset ready", req_ready, 1);
        check("R6", "reset err", err, 0);
        rst_n = 1'b1;
        run_req(32'h0000_0FF8, 32'h0000_1003, 5000, "R3");
        run_req(32'h0000_0000, 32'h0001_0000, 4096, "aligned page");
        run_req(32'h0000_0FFF, 32'h0000_2000, 2, "page straddle");
        run_req(32'h0000_0010, 32'h0000_0020, 0, "zero");
        run_req(32'h0000_0123, 32'h0000_0456, 1, "one byte");
        run_req(32'h0000_5007, 32'h0000_700F, 9000, "long");
        for (int i = 0; i < 40; i++) begin
            logic [31:0] s = $urandom & 32'h7FFF_FFFF;
            logic [31:0] d = $urandom & 32'h7FFF_FFFF;
            int len = (($urandom % 4) == 0) ? int'($urandom % 17) : int'($urandom % 3000);
            run_req(s, d, len, "random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule